// File: doc/BRIEF.md
# Serial Divide-by-Three Unit

This unit divides an unsigned binary number of any length by three while the number streams in one bit per clock, most significant bit first. The only state it keeps between bits is the remainder of the prefix seen so far, held as one of three codes. Each accepted bit produces one quotient bit, so the stream of quotient bits read out in order is the integer quotient. After the last bit, the remainder port holds the final remainder.

A producer raises `bit_vld` for every bit it presents. It raises `start` together with the first bit of a new number. That bit is then evaluated as if the running remainder were zero, so numbers can follow each other with no idle cycle between them. Cycles with `bit_vld` low are stalls: the remainder is frozen and no quotient bit is flagged.

Top module: `ser_div3`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge (synchronous, active low), the next state has `rem_out` = 0, `q_vld` = 0 and `q_bit` = 0.
- R2: For an accepted bit b with `start` low and current remainder r, `rem_out` after that edge equals (2·r + b) mod 3.
- R3: One clock after an accepted bit, `q_vld` is 1 and `q_bit` is 1 exactly when 2·r + b ≥ 3 (r is the remainder before the bit).
- R4: After an edge where `bit_vld` was low, `rem_out` keeps its previous value and `q_vld` is 0.
- R5: An accepted bit with `start` high is evaluated from remainder 0: afterwards `rem_out` equals the bit and `q_bit` is 0, whatever the remainder was before.
- R6: For a number of 1 to 64 bits sent MSB first, starting with `start`, the quotient bits collected in arrival order equal the number divided by three, and `rem_out` after the last bit equals the number modulo three, with or without stall cycles between bits.
- R7: `rem_out` only takes the codes 00, 01 and 10 (remainders 0, 1, 2); code 11 never appears.
- R8: `q_bit` is 0 in every cycle where `q_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Marks the current bit as the first bit of a new number; sampled only with `bit_vld` |
| bit_vld | input | 1 | The current `bit_in` is a data bit to be consumed |
| bit_in | input | 1 | Serial dividend bit, most significant first |
| q_vld | output | 1 | `q_bit` carries the quotient bit of the bit accepted at the last edge |
| q_bit | output | 1 | Quotient bit, 0 when `q_vld` is low |
| rem_out | output | 2 | Running remainder modulo three, binary coded |

## Verification
The unit is driven with all-zero and single-bit numbers, which only visit the remainder-0 and remainder-1 arcs, and with an all-ones 64-bit value and an alternating pattern, which cycle through every arc and make every quotient bit depend on the remainder being correct. Random numbers of random length, with random stall gaps, separate a correct hold on stalls from one that keeps advancing. Numbers are sent back to back so that the `start` bit of each arrives while the previous number left a nonzero remainder, which exposes a start that fails to clear it.

// File: rtl/div3_pkg.sv
// Shared encoding for the serial divide-by-three unit.
// Assumes a two-bit binary remainder code; 2'b11 is never produced.
package div3_pkg;
    localparam int STATE_W = 2;
    localparam logic [STATE_W-1:0] REM_ZERO = 2'b00;
    localparam logic [STATE_W-1:0] REM_ONE  = 2'b01;
    localparam logic [STATE_W-1:0] REM_TWO  = 2'b10;
endpackage

// File: rtl/div3_step.sv
// Combinational arc logic: from the present remainder and one input bit,
// gives the next remainder and the quotient bit of that arc.
// Assumes the caller forces the remainder to zero on the first bit via clear.
module div3_step
    import div3_pkg::*;
#(
    parameter int W = STATE_W
) (
    input  logic [W-1:0] cur_rem,
    input  logic         clear,
    input  logic         din,
    output logic [W-1:0] nxt_rem,
    output logic         qout
);
    logic [W-1:0] base;

    // Choose the remainder the arc starts from.
    always_comb base = clear ? REM_ZERO : cur_rem;

    // Arc table of (2r + b): new remainder and quotient bit.
    always_comb begin
        case (base)
            REM_ZERO: begin nxt_rem = din ? REM_ONE : REM_ZERO; qout = 1'b0; end
            REM_ONE:  begin nxt_rem = din ? REM_ZERO : REM_TWO; qout = din;  end
            REM_TWO:  begin nxt_rem = din ? REM_TWO : REM_ONE;  qout = 1'b1; end
            default:  begin nxt_rem = REM_ZERO;                 qout = 1'b0; end
        endcase
    end
endmodule

// File: rtl/div3_state_reg.sv
// Remainder register with synchronous active-low reset and load enable.
// Assumes load is high only on accepted bits.
module div3_state_reg
    import div3_pkg::*;
#(
    parameter int W = STATE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold the running remainder, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= REM_ZERO;
        else if (load) q <= d;
    end
endmodule

// File: rtl/div3_out_reg.sv
// Registers the quotient bit and its valid flag for one cycle per accepted bit.
// Assumes vld marks the cycles whose q must be presented.
module div3_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic q,
    output logic q_vld,
    output logic q_bit
);
    // Present the arc output, quiet when no bit was taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= 1'b0;
            q_bit <= 1'b0;
        end else begin
            q_vld <= vld;
            q_bit <= vld & q;
        end
    end
endmodule

// File: rtl/ser_div3.sv
// Serial MSB-first divide-by-three. Keeps only the remainder as state and
// emits one registered quotient bit per accepted input bit.
// Assumes start accompanies the first bit of each number.
module ser_div3
    import div3_pkg::*;
#(
    parameter int W = STATE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         bit_vld,
    input  logic         bit_in,
    output logic         q_vld,
    output logic         q_bit,
    output logic [W-1:0] rem_out
);
    logic [W-1:0] rem_q;
    logic [W-1:0] rem_d;
    logic         arc_q;

    div3_step #(.W(W)) u_step (
        .cur_rem (rem_q),
        .clear   (start),
        .din     (bit_in),
        .nxt_rem (rem_d),
        .qout    (arc_q)
    );

    div3_state_reg #(.W(W)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bit_vld),
        .d     (rem_d),
        .q     (rem_q)
    );

    div3_out_reg u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (bit_vld),
        .q     (arc_q),
        .q_vld (q_vld),
        .q_bit (q_bit)
    );

    assign rem_out = rem_q;
endmodule

// File: rtl/div3_chk.sv
// Property checker for ser_div3, attached by bind below.
// Assumes the port names of ser_div3.
module div3_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       bit_vld,
    input logic       bit_in,
    input logic       q_vld,
    input logic       q_bit,
    input logic [1:0] rem_out
);
    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (rem_out == 2'b00 && !q_vld && !q_bit)); // R1
    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !start && !bit_in && rem_out == 2'b00) |=> (rem_out == 2'b00 && !q_bit)); // R2
    AST_ACCEPT_FLAG: assert property (@(posedge clk) disable iff (!rst_n) bit_vld |=> q_vld); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(rem_out) && !q_vld)); // R4
    AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && start) |=> (rem_out == {1'b0, $past(bit_in)} && !q_bit)); // R5
    AST_REM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) rem_out != 2'b11); // R7
    AST_QBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !q_vld |-> !q_bit); // R8
endmodule

bind ser_div3 div3_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .q_vld   (q_vld),
    .q_bit   (q_bit),
    .rem_out (rem_out)
);

// File: tb/ser_div3_test.sv
// Scoreboard bench: the driver pushes expected arcs, the monitor pops them.
module ser_div3_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       q_vld;
    logic       q_bit;
    logic [1:0] rem_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic       qb;
        logic [1:0] rem;
        logic       first;
    } exp_t;
    exp_t exq[$];

    logic [63:0] q_acc = '0;
    logic [1:0]  exp_rem = 2'b00;
    int          model_rem = 0;

    ser_div3 uut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_vld(bit_vld),
        .bit_in(bit_in), .q_vld(q_vld), .q_bit(q_bit), .rem_out(rem_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare each flagged quotient bit and remainder with the queue head.
    always @(negedge clk) begin
        if (!rst_n) begin
            exp_rem = 2'b00;
        end else if (q_vld) begin
            if (exq.size() == 0) begin
                chk(1'b0, "R3 unexpected q_vld", 1, 0);
            end else begin
                exp_t e;
                e = exq.pop_front();
                chk(q_bit == e.qb, e.first ? "R5 q_bit" : "R3 q_bit", q_bit, e.qb);
                chk(rem_out == e.rem, e.first ? "R5 rem_out" : "R2 rem_out", rem_out, e.rem);
                chk(rem_out != 2'b11, "R7 code", rem_out, e.rem);
                exp_rem = e.rem;
                q_acc = e.first ? {63'd0, e.qb} : {q_acc[62:0], e.qb};
            end
        end else begin
            chk(rem_out == exp_rem, "R4 hold", rem_out, exp_rem);
            chk(q_bit == 1'b0, "R8 quiet", q_bit, 0);
        end
    end

    // Driver: send one number MSB first, with optional random stalls.
    task automatic send_num(input logic [63:0] n_in, input int len, input int stall_pct);
        logic [63:0] n;
        n = (len == 64) ? n_in : (n_in & ((64'd1 << len) - 64'd1));
        for (int i = len - 1; i >= 0; i--) begin
            while (stall_pct > 0 && ($urandom % 100) < stall_pct) begin
                @(posedge clk); #1;
                bit_vld = 1'b0; start = 1'b0; bit_in = $urandom;
            end
            @(posedge clk); #1;
            begin
                exp_t e;
                int v;
                e.first = (i == len - 1);
                if (e.first) model_rem = 0;
                v = 2 * model_rem + int'(n[i]);
                e.qb = (v >= 3);
                model_rem = v % 3;
                e.rem = model_rem[1:0];
                exq.push_back(e);
            end
            bit_vld = 1'b1; start = (i == len - 1); bit_in = n[i];
        end
        @(posedge clk); #1;
        bit_vld = 1'b0; start = 1'b0;
        @(negedge clk); #1;
        chk(exq.size() == 0, "R6 drained", exq.size(), 0);
        chk(q_acc == n / 3, "R6 quotient", q_acc, n / 3);
        chk(rem_out == 2'(n % 3), "R6 remainder", rem_out, n % 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(rem_out == 2'b00, "R1 rem", rem_out, 0);
        chk(q_vld == 1'b0, "R1 q_vld", q_vld, 0);
        chk(q_bit == 1'b0, "R1 q_bit", q_bit, 0);
        rst_n = 1'b1;
        send_num(64'd0, 8, 0);
        send_num(64'd1, 1, 0);
        send_num(64'd2, 2, 0);
        send_num(64'hFFFF_FFFF_FFFF_FFFF, 64, 0);
        send_num(64'h5555_5555_5555_5555, 64, 30);
        send_num(64'd7, 3, 0);
        send_num(64'd3, 2, 0);
        for (int k = 0; k < 40; k++) begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            send_num(r, 1 + int'($urandom % 64), (k % 2) ? 25 : 0);
        end
        // Reset in the middle of a number, then check the clean state (R1).
        @(posedge clk); #1;
        bit_vld = 1'b1; start = 1'b1; bit_in = 1'b1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        bit_vld = 1'b0; start = 1'b0;
        chk(rem_out == 2'b00, "R1 rem mid", rem_out, 0);
        chk(q_vld == 1'b0, "R1 q_vld mid", q_vld, 0);
        rst_n = 1'b1;
        send_num(64'd5, 3, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule